// File: doc/BRIEF.md
# Idle-Timeout and Send-Now Packet Flusher

This block decides when the bytes sitting in an upstream-bound buffer should leave as a packet. It watches the buffer's fill level and counts idle millisecond ticks against a programmable limit. The limit runs from 1 to 255 ms, with 16 ms as the customary setting, and a setting of 0 acts as 1 ms. Any arriving byte restarts the idle count. A flush is also requested at once when a full 64-byte packet is waiting.

An active-low strobe pin has two uses. While the link is active, a falling edge on it marks a send-now request. The request stays pending until the link offers a packet slot, and that slot then carries whatever is buffered, even nothing at all. While the link is suspended, the same edge becomes a one-cycle resume request, but only if remote wakeup is enabled. A power-off output follows the suspend state, so external loads can be shut down.

The flush request and byte count are combinational from the block's state and the current level. The link samples them in the cycle it raises its slot request.

Top module: `pkt_flusher`

## Requirements
- R1: After reset, flushReq, flushCount, resumeReq and powerOff are all 0.
- R2: With a nonzero level that does not grow, flushReq rises in the cycle after the idle count reaches the effective timeout. The idle count is the number of msTick cycles since the last restart.
- R3: A timeoutMs value of 0 behaves as a timeout of 1 ms.
- R4: A cycle in which bufLevel is larger than in the previous cycle restarts the idle count at 0.
- R5: When bufLevel is at least 64, flushReq is high in the same cycle and flushCount is 64. Otherwise flushCount equals bufLevel.
- R6: Outside suspend, a falling edge on sendImmN sets a pending send-now. From the next cycle, flushReq stays high until a cycle with slotReq high.
- R7: A pending send-now with an empty buffer raises flushReq with flushCount 0, which is a zero-length packet.
- R8: A cycle with slotReq and flushReq both high consumes the request. It clears the pending send-now (unless a new edge arrives in that cycle) and restarts the idle count.
- R9: In suspend with remoteWakeEn high, a falling edge on sendImmN gives a resumeReq pulse of exactly one cycle in the next cycle, and sets no pending send-now.
- R10: In suspend with remoteWakeEn low, a falling edge on sendImmN produces neither a resume request nor a send-now.
- R11: powerOff equals the value suspended had in the previous cycle.
- R12: The idle count saturates at 255. A zero level never raises a timeout flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufLevel | input | 9 | Bytes currently buffered |
| msTick | input | 1 | One-cycle pulse per millisecond |
| timeoutMs | input | 8 | Idle timeout in ms (0 acts as 1) |
| suspended | input | 1 | Link is in suspend |
| remoteWakeEn | input | 1 | Remote wakeup permitted |
| sendImmN | input | 1 | Active-low send-now / wakeup strobe |
| slotReq | input | 1 | Link offers a packet slot this cycle |
| flushReq | output | 1 | A packet should be sent in the next slot |
| flushCount | output | 7 | Bytes that packet carries (0 to 64) |
| resumeReq | output | 1 | One-cycle resume request |
| powerOff | output | 1 | High while the link is suspended |

## Verification
The assertions assume that msTick, slotReq and sendImmN are synchronous to clk and stable between edges. They also assume that bufLevel moves only by the buffer's own writes and reads, and that powerOff and resumeReq are judged only from the second cycle after reset. The stimulus applies every input just after the falling edge and holds it for a full cycle. It keeps the level within the 9-bit range, and it toggles suspend only between strobes in the directed part. The random part mixes these freely while staying synchronous.

// File: rtl/pflush_pkg.sv
package pflush_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearIdle;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic full;
    logic timedOut;
  } dpStatus_t;

endpackage

// File: rtl/pflush_dp.sv
module pflush_dp
  import pflush_pkg::*;
#(
  parameter int LVL_W   = 9,
  parameter int MAX_PKT = 64,
  parameter int TO_W    = 8,
  localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] bufLevel,
  input  logic             msTick,
  input  logic [TO_W-1:0]  timeoutMs,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        status,
  output logic [CNT_W-1:0] flushCount
);

  localparam logic [LVL_W-1:0] MAX_LVL  = LVL_W'(MAX_PKT);
  localparam logic [TO_W-1:0]  IDLE_TOP = '1;

  logic [LVL_W-1:0] lvlPrev;
  logic [TO_W-1:0]  idleCnt;
  logic [TO_W-1:0]  effTo;
  logic             grew;

  assign grew  = bufLevel > lvlPrev;
  assign effTo = (timeoutMs == '0) ? TO_W'(1) : timeoutMs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlPrev <= '0;
      idleCnt <= '0;
    end else begin
      lvlPrev <= bufLevel;
      if (grew || ctl.clearIdle)
        idleCnt <= '0;
      else if (msTick && idleCnt != IDLE_TOP)
        idleCnt <= idleCnt + TO_W'(1);
    end
  end

  assign status.full     = bufLevel >= MAX_LVL;
  assign status.timedOut = (idleCnt >= effTo) && (bufLevel != '0);
  assign flushCount      = status.full ? CNT_W'(MAX_PKT) : bufLevel[CNT_W-1:0];

  // R4: a growing level restarts idle time
  p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    grew |=> idleCnt == '0);

  // R2: each tick advances the idle count when nothing restarts it
  p_idle_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!grew && !ctl.clearIdle && msTick && idleCnt != IDLE_TOP)
      |=> idleCnt == $past(idleCnt) + TO_W'(1));

  // R12: saturated idle count holds
  p_idle_sat_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!grew && !ctl.clearIdle && idleCnt == IDLE_TOP) |=> idleCnt == IDLE_TOP);

  // R5: packet size never exceeds the maximum
  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushCount <= CNT_W'(MAX_PKT));

endmodule

// File: rtl/pflush_ctl.sv
module pflush_ctl
  import pflush_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendImmN,
  input  logic       suspended,
  input  logic       remoteWakeEn,
  input  logic       slotReq,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       flushReq,
  output logic       resumeReq,
  output logic       powerOff
);

  logic siPrevN;
  logic siEdge;
  logic siPending;
  logic take;

  assign siEdge   = siPrevN && !sendImmN;
  assign flushReq = siPending || status.full || status.timedOut;
  assign take     = slotReq && flushReq;
  assign ctl.clearIdle = take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siPrevN   <= 1'b1;
      siPending <= 1'b0;
      resumeReq <= 1'b0;
      powerOff  <= 1'b0;
    end else begin
      siPrevN   <= sendImmN;
      powerOff  <= suspended;
      resumeReq <= siEdge && suspended && remoteWakeEn;
      if (siEdge && !suspended)
        siPending <= 1'b1;
      else if (take)
        siPending <= 1'b0;
    end
  end

  // R6: a pending send-now survives until a slot takes it
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (siPending && !slotReq) |=> siPending);

  // R8: a taken slot with no new edge clears the pending send-now
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (take && !siEdge) |=> !siPending);

  // R9: resume only follows a suspended, wake-enabled cycle
  p_resume_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> ($past(suspended) && $past(remoteWakeEn)));

  // R9: resume is a single-cycle pulse
  p_resume_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |=> !resumeReq);

  // R10: no resume without remote wakeup
  p_no_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    !remoteWakeEn |=> !resumeReq);

  // R11: power-off tracks suspend one cycle later
  p_pwr_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (powerOff == $past(suspended)));

endmodule

// File: rtl/pkt_flusher.sv
module pkt_flusher
  import pflush_pkg::*;
#(
  parameter int LVL_W   = 9,
  parameter int MAX_PKT = 64,
  parameter int TO_W    = 8,
  localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] bufLevel,
  input  logic             msTick,
  input  logic [TO_W-1:0]  timeoutMs,
  input  logic             suspended,
  input  logic             remoteWakeEn,
  input  logic             sendImmN,
  input  logic             slotReq,
  output logic             flushReq,
  output logic [CNT_W-1:0] flushCount,
  output logic             resumeReq,
  output logic             powerOff
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  pflush_dp #(
    .LVL_W  (LVL_W),
    .MAX_PKT(MAX_PKT),
    .TO_W   (TO_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .bufLevel  (bufLevel),
    .msTick    (msTick),
    .timeoutMs (timeoutMs),
    .ctl       (ctl),
    .status    (status),
    .flushCount(flushCount)
  );

  pflush_ctl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .sendImmN    (sendImmN),
    .suspended   (suspended),
    .remoteWakeEn(remoteWakeEn),
    .slotReq     (slotReq),
    .status      (status),
    .ctl         (ctl),
    .flushReq    (flushReq),
    .resumeReq   (resumeReq),
    .powerOff    (powerOff)
  );

endmodule

// File: tb/tb_pkt_flusher.sv
`timescale 1ns/1ps
module tb_pkt_flusher;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] bufLevel = '0;
  logic       msTick = 1'b0;
  logic [7:0] timeoutMs = 8'd16;
  logic       suspended = 1'b0;
  logic       remoteWakeEn = 1'b0;
  logic       sendImmN = 1'b1;
  logic       slotReq = 1'b0;
  logic       flushReq;
  logic [6:0] flushCount;
  logic       resumeReq;
  logic       powerOff;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mIdle = 0, mPrevLvl = 0;
  bit mPend = 0, mSiPrev = 1, mRes = 0, mPwr = 0;

  always #2.5 clk = ~clk;

  pkt_flusher dut (
    .clk(clk), .rstN(rstN), .bufLevel(bufLevel), .msTick(msTick),
    .timeoutMs(timeoutMs), .suspended(suspended), .remoteWakeEn(remoteWakeEn),
    .sendImmN(sendImmN), .slotReq(slotReq), .flushReq(flushReq),
    .flushCount(flushCount), .resumeReq(resumeReq), .powerOff(powerOff)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expFlush();
    int eff = (timeoutMs == 0) ? 1 : int'(timeoutMs);
    int lvl = int'(bufLevel);
    return (mPend || lvl >= 64 || (mIdle >= eff && lvl != 0)) ? 1 : 0;
  endfunction

  // one clock: compare against model, advance model, wait to next falling edge
  task automatic cyc(int lvl, bit tick, bit siN, bit slot);
    bufLevel = 9'(lvl); msTick = tick; sendImmN = siN; slotReq = slot;
    #1;
    begin
      int ef   = expFlush();
      int ec   = (lvl >= 64) ? 64 : lvl;
      bit strb = !siN && mSiPrev;
      bit grew = lvl > mPrevLvl;
      bit take = slot && (ef == 1);
      chk("R2 R5 R6 flushReq", int'(flushReq), ef);
      chk("R5 R7 flushCount", int'(flushCount), ec);
      chk("R9 R10 resumeReq", int'(resumeReq), int'(mRes));
      chk("R11 powerOff", int'(powerOff), int'(mPwr));
      if (grew || take) mIdle = 0;
      else if (tick && mIdle < 255) mIdle++;
      if (strb && !suspended) mPend = 1;
      else if (take) mPend = 0;
      mRes = strb && suspended && remoteWakeEn;
      mPwr = suspended;
      mSiPrev = siN;
      mPrevLvl = lvl;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lvl;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flushReq", int'(flushReq), 0);
    chk("R1 flushCount", int'(flushCount), 0);
    chk("R1 resumeReq", int'(resumeReq), 0);
    chk("R1 powerOff", int'(powerOff), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: timeout of 3 ticks
    timeoutMs = 8'd3;
    cyc(5, 0, 1, 0);
    cyc(5, 1, 1, 0);
    cyc(5, 0, 1, 0);
    cyc(5, 1, 1, 0);
    #1 chk("R2 before limit", int'(flushReq), 0);
    cyc(5, 1, 1, 0);
    #1 chk("R2 at limit", int'(flushReq), 1);
    chk("R2 count", int'(flushCount), 5);
    cyc(5, 0, 1, 1);
    #1 chk("R8 slot consumed", int'(flushReq), 0);

    // R4: growth restarts idle
    timeoutMs = 8'd2;
    cyc(5, 1, 1, 0);
    cyc(6, 1, 1, 0);
    cyc(6, 1, 1, 0);
    #1 chk("R4 restart", int'(flushReq), 0);
    cyc(6, 1, 1, 0);
    cyc(6, 0, 1, 1);

    // R3: zero timeout acts as one
    timeoutMs = 8'd0;
    cyc(6, 1, 1, 0);
    #1 chk("R3 zero timeout", int'(flushReq), 1);
    cyc(6, 0, 1, 1);

    // R5: full packet
    timeoutMs = 8'd255;
    cyc(70, 0, 1, 0);
    #1 chk("R5 full flag", int'(flushReq), 1);
    chk("R5 capped count", int'(flushCount), 64);
    cyc(64, 0, 1, 1);
    #1 chk("R5 exact 64", int'(flushReq), 1);
    cyc(10, 0, 1, 0);
    #1 chk("R5 below full", int'(flushReq), 0);

    // R6 / R7: send-now with empty buffer
    cyc(0, 0, 0, 0);
    #1 chk("R7 zero-length req", int'(flushReq), 1);
    chk("R7 zero count", int'(flushCount), 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    #1 chk("R6 pending held", int'(flushReq), 1);
    cyc(0, 0, 1, 1);
    #1 chk("R8 pending cleared", int'(flushReq), 0);

    // R9 / R11: suspend with wakeup
    suspended = 1'b1; remoteWakeEn = 1'b1;
    cyc(0, 0, 1, 0);
    #1 chk("R11 power off", int'(powerOff), 1);
    cyc(0, 0, 0, 0);
    #1 chk("R9 resume pulse", int'(resumeReq), 1);
    chk("R9 no send-now", int'(flushReq), 0);
    cyc(0, 0, 1, 0);
    #1 chk("R9 pulse ends", int'(resumeReq), 0);

    // R10: suspend without wakeup
    remoteWakeEn = 1'b0;
    cyc(0, 0, 0, 0);
    #1 chk("R10 no resume", int'(resumeReq), 0);
    chk("R10 no send-now", int'(flushReq), 0);
    cyc(0, 0, 1, 0);
    suspended = 1'b0;
    cyc(0, 0, 1, 0);
    #1 chk("R11 power on", int'(powerOff), 0);

    // R12: empty never times out; count saturates
    timeoutMs = 8'd1;
    for (int i = 0; i < 300; i++) cyc(0, 1, 1, 0);
    #1 chk("R12 empty no flush", int'(flushReq), 0);
    timeoutMs = 8'd255;
    cyc(3, 0, 1, 0);
    for (int i = 0; i < 260; i++) cyc(3, 1, 1, 0);
    #1 chk("R12 saturated flush", int'(flushReq), 1);
    cyc(3, 0, 1, 1);

    // mixed random traffic against the model
    lvl = 3;
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 3 && lvl < 400) lvl += int'($urandom_range(1, 20));
      else if (r == 3) lvl = (lvl > 64) ? lvl - 64 : 0;
      if (lvl > 511) lvl = 511;
      timeoutMs = (i % 500 == 0) ? 8'($urandom_range(0, 6)) : timeoutMs;
      if (i % 97 == 0) suspended = ~suspended;
      if (i % 211 == 0) remoteWakeEn = ~remoteWakeEn;
      cyc(lvl, ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 4) == 0));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule